// File: doc/BRIEF.md
# SKP Rate-Match Elastic Buffer

This block carries a byte-wide decoded symbol stream, each byte with a control flag, from a recovered write clock to a local read clock. The two clocks run at nominally equal rates with a small offset. Over time that offset would empty or overfill any fixed store. The buffer absorbs the drift at SKP ordered sets, which begin with a COM control symbol followed by one or more SKP control symbols. When the store runs high it leaves out one SKP of a set. When it runs low it adds one SKP to a set. All other symbols pass through untouched and in order.

Each change is reported on a 3-bit status output in the cycle that carries the COM of the affected set. Two further events are reported in line with the output stream. When an arriving byte finds the store full, that byte is discarded and the writer is never stalled. When the reader runs dry, the output goes invalid and the reader waits until the store has refilled to its midpoint. Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Each domain has its own asynchronous active-low reset, which is released in step with that domain's clock.

Top module: `skp_elastic_buf`

## Requirements
- R1: After reset rd_valid is 0 and rd_status is 3'b000, and no valid byte is delivered until the read side has counted at least START_LVL (default 8) stored entries.
- R2: Every symbol that is neither discarded on overflow nor a removed or added SKP leaves the buffer in arrival order, with its data and K flag unchanged.
- R3: A symbol is removed only if it is a K28.0 SKP (K=1, data 8'h1C) that directly follows a K28.5 COM (K=1, data 8'hBC). At most one symbol is removed per set. A removal happens only when the write-side fill count is at least DEL_LVL (default 14) as that SKP arrives.
- R4: The COM of a set that lost a SKP is delivered with rd_status = 3'b010 for that single cycle.
- R5: When a COM is delivered while the read-side fill count is at most INS_LVL (default 3) and the next stored symbol is a SKP, one extra SKP is delivered in the cycle right after that COM. The COM carries rd_status = 3'b001, and the extra SKP carries 3'b000.
- R6: While the fill count stays between the two thresholds, SKP ordered sets are delivered with their SKP count unchanged.
- R7: A byte that arrives when the write side counts DEPTH (default 16) stored entries is discarded. The next byte that is stored is later delivered with rd_status = 3'b101.
- R8: If the reader has started and the read side counts no stored entry, rd_valid drops to 0 and rd_status shows 3'b110 for exactly one cycle. Delivery then resumes only after the read side counts START_LVL entries again.
- R9: In every other cycle rd_status is 3'b000. While rd_valid is 0 it is 3'b000 or 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_valid | input | 1 | A symbol is presented on wr_data / wr_is_k |
| wr_data | input | 8 | Decoded symbol byte |
| wr_is_k | input | 1 | Symbol is a control (K) character |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_valid | output | 1 | rd_data / rd_is_k carry a symbol this cycle |
| rd_data | output | 8 | Delivered symbol byte |
| rd_is_k | output | 1 | Delivered symbol is a control character |
| rd_status | output | 3 | Event code: 000 none, 001 SKP added, 010 SKP removed, 101 overflow drop, 110 underflow |

## Verification
A stale or corrupted pointer shows at once at the ports. It repeats a symbol or skips one in the delivered order, which the in-order compare catches on the next valid byte. A fill count that is wrong on either side moves the insert and delete decisions. This shows within one SKP ordered set, either as a set whose SKP count changed with no code on its COM, or as a code on a COM whose set came through intact. A lost overflow or underflow marker shows as discarded bytes that no 101 code explains, or as a missing 110 pulse when the stream starves.

// File: rtl/eb_pkg.sv
package eb_pkg;

  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_SKP = 8'h1C;

  localparam logic [2:0] ST_NONE = 3'b000;
  localparam logic [2:0] ST_INS  = 3'b001;
  localparam logic [2:0] ST_DEL  = 3'b010;
  localparam logic [2:0] ST_OVF  = 3'b101;
  localparam logic [2:0] ST_UND  = 3'b110;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_DEL  = 2'd1,
    TAG_OVF  = 2'd2
  } eb_tag_t;

  typedef struct packed {
    eb_tag_t    tag;
    logic       k;
    logic [7:0] d;
  } eb_entry_t;

endpackage

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
  parameter int PW = 5
) (
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);

  logic [PW-1:0] s1_q;
  logic [PW-1:0] s2_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // Each binary bit is the parity of the Gray bits at and above it.
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      bin_o[i] = ^(s2_q >> i);
    end
  end

endmodule

// File: rtl/eb_store.sv
module eb_store import eb_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wr_clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  eb_entry_t     wentry_i,
  input  logic [AW-1:0] raddr0_i,
  input  logic [AW-1:0] raddr1_i,
  output eb_entry_t     rentry0_o,
  output logic [8:0]    rsym1_o
);

  eb_entry_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we_i && (waddr_i == AW'(g));
    always_ff @(posedge wr_clk) begin
      if (ent_en) begin
        mem_q[g] <= wentry_i;
      end
    end
  end

  assign rentry0_o = mem_q[raddr0_i];
  assign rsym1_o   = {mem_q[raddr1_i].k, mem_q[raddr1_i].d};

endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side import eb_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int DEL_LVL = 14,
  parameter int AW      = 4,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  input  logic          in_k_i,
  input  logic [PW-1:0] rptr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output eb_entry_t     wentry_o,
  output logic [PW-1:0] wgray_o,
  output logic [PW-1:0] occ_o
);

  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] wgray_d;
  logic          hold_vld_q, hold_vld_d;
  logic [8:0]    hold_q, hold_d;
  logic          ovf_q, ovf_d;
  logic          full, hold_com, in_skp, skip_skp;

  assign waddr_o = wptr_q[AW-1:0];

  always_comb begin
    occ_o    = wptr_q - rptr_i;
    full     = (occ_o >= PW'(DEPTH));
    hold_com = hold_vld_q && (hold_q == {1'b1, SYM_COM});
    in_skp   = in_k_i && (in_data_i == SYM_SKP);
    // The held COM is written with a removal tag and the arriving SKP is skipped.
    skip_skp = in_valid_i && hold_com && in_skp && !full && !ovf_q &&
               (occ_o >= PW'(DEL_LVL));
    we_o     = in_valid_i && hold_vld_q && !full;

    wentry_o.d   = hold_q[7:0];
    wentry_o.k   = hold_q[8];
    wentry_o.tag = ovf_q ? TAG_OVF : (skip_skp ? TAG_DEL : TAG_NONE);

    hold_vld_d = hold_vld_q;
    hold_d     = hold_q;
    if (in_valid_i) begin
      hold_vld_d = !skip_skp;
      hold_d     = {in_k_i, in_data_i};
    end

    ovf_d = ovf_q;
    if (in_valid_i && hold_vld_q && full) begin
      ovf_d = 1'b1;
    end else if (we_o) begin
      ovf_d = 1'b0;
    end

    wptr_d  = wptr_q + PW'(we_o);
    wgray_d = wptr_d ^ (wptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      wgray_o    <= '0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      ovf_q      <= 1'b0;
    end else if (in_valid_i) begin
      wptr_q     <= wptr_d;
      wgray_o    <= wgray_d;
      hold_vld_q <= hold_vld_d;
      hold_q     <= hold_d;
      ovf_q      <= ovf_d;
    end
  end

endmodule

// File: rtl/eb_rd_side.sv
module eb_rd_side import eb_pkg::*; #(
  parameter int START_LVL = 8,
  parameter int INS_LVL   = 3,
  parameter int AW        = 4,
  parameter int PW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] wptr_i,
  input  eb_entry_t     head_i,
  input  logic [8:0]    nxt_i,
  output logic [AW-1:0] raddr0_o,
  output logic [AW-1:0] raddr1_o,
  output logic [PW-1:0] rgray_o,
  output logic          out_valid_o,
  output logic [7:0]    out_data_o,
  output logic          out_k_o,
  output logic [2:0]    out_status_o
);

  logic [PW-1:0] rptr_q, rptr_d, rgray_d, occ;
  logic          run_q, run_d;
  logic          ins_q, ins_d;
  logic          v_d, k_d;
  logic [7:0]    d_d;
  logic [2:0]    st_d;
  logic          head_com, nxt_skp;

  assign raddr0_o = rptr_q[AW-1:0];
  assign raddr1_o = rptr_q[AW-1:0] + AW'(1);

  always_comb begin
    occ      = wptr_i - rptr_q;
    head_com = head_i.k && (head_i.d == SYM_COM);
    nxt_skp  = (nxt_i == {1'b1, SYM_SKP});
    rptr_d   = rptr_q;
    run_d    = run_q;
    ins_d    = 1'b0;
    v_d      = 1'b0;
    k_d      = 1'b0;
    d_d      = '0;
    st_d     = ST_NONE;
    if (ins_q) begin
      // Extra SKP of an enlarged set; the read pointer holds still.
      v_d = 1'b1;
      k_d = 1'b1;
      d_d = SYM_SKP;
    end else if (!run_q) begin
      if (occ >= PW'(START_LVL)) begin
        run_d = 1'b1;
      end
    end else if (occ == '0) begin
      st_d  = ST_UND;
      run_d = 1'b0;
    end else begin
      v_d    = 1'b1;
      k_d    = head_i.k;
      d_d    = head_i.d;
      rptr_d = rptr_q + PW'(1);
      case (head_i.tag)
        TAG_DEL: st_d = ST_DEL;
        TAG_OVF: st_d = ST_OVF;
        default: begin
          if (head_com && nxt_skp && (occ >= PW'(2)) && (occ <= PW'(INS_LVL))) begin
            st_d  = ST_INS;
            ins_d = 1'b1;
          end
        end
      endcase
    end
    rgray_d = rptr_d ^ (rptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q       <= '0;
      rgray_o      <= '0;
      run_q        <= 1'b0;
      ins_q        <= 1'b0;
      out_valid_o  <= 1'b0;
      out_k_o      <= 1'b0;
      out_data_o   <= '0;
      out_status_o <= ST_NONE;
    end else begin
      rptr_q       <= rptr_d;
      rgray_o      <= rgray_d;
      run_q        <= run_d;
      ins_q        <= ins_d;
      out_valid_o  <= v_d;
      out_k_o      <= k_d;
      out_data_o   <= d_d;
      out_status_o <= st_d;
    end
  end

endmodule

// File: rtl/skp_elastic_buf.sv
module skp_elastic_buf import eb_pkg::*; #(
  parameter int DEPTH     = 16,
  parameter int START_LVL = DEPTH / 2,
  parameter int DEL_LVL   = 14,
  parameter int INS_LVL   = 3
) (
  input  logic       wr_clk,
  input  logic       wr_rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_is_k,
  input  logic       rd_clk,
  input  logic       rd_rst_n,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_is_k,
  output logic [2:0] rd_status
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr0, raddr1;
  eb_entry_t     wentry, rentry0;
  logic [8:0]    rsym1;
  logic [PW-1:0] wgray, rgray, wptr_sync, rptr_sync, wr_occ;

  eb_wr_side #(.DEPTH(DEPTH), .DEL_LVL(DEL_LVL), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .in_valid_i(wr_valid), .in_data_i(wr_data), .in_k_i(wr_is_k),
    .rptr_i(rptr_sync),
    .we_o(we), .waddr_o(waddr), .wentry_o(wentry),
    .wgray_o(wgray), .occ_o(wr_occ)
  );

  eb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .wr_clk(wr_clk), .we_i(we), .waddr_i(waddr), .wentry_i(wentry),
    .raddr0_i(raddr0), .raddr1_i(raddr1),
    .rentry0_o(rentry0), .rsym1_o(rsym1)
  );

  eb_gray_sync #(.PW(PW)) u_w2r (
    .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .gray_i(wgray), .bin_o(wptr_sync)
  );

  eb_gray_sync #(.PW(PW)) u_r2w (
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .gray_i(rgray), .bin_o(rptr_sync)
  );

  eb_rd_side #(.START_LVL(START_LVL), .INS_LVL(INS_LVL), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .wptr_i(wptr_sync), .head_i(rentry0), .nxt_i(rsym1),
    .raddr0_o(raddr0), .raddr1_o(raddr1), .rgray_o(rgray),
    .out_valid_o(rd_valid), .out_data_o(rd_data), .out_k_o(rd_is_k),
    .out_status_o(rd_status)
  );

endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          rd_is_k,
  input logic [2:0]    rd_status,
  input logic [PW-1:0] wr_occ
);

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= PW'(DEPTH)); // R7

  AST_STATUS_LEGAL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110}); // R9

  AST_IDLE_QUIET: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_valid |-> (rd_status == 3'b000 || rd_status == 3'b110)); // R9

  AST_INS_ON_COM: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b001 |-> (rd_valid && rd_is_k && rd_data == 8'hBC)); // R5

  AST_INS_EXTRA_SKP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b001 |=> (rd_valid && rd_is_k && rd_data == 8'h1C && rd_status == 3'b000)); // R5

  AST_DEL_ON_COM: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b010 |-> (rd_valid && rd_is_k && rd_data == 8'hBC)); // R4

  AST_OVF_ON_DATA: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b101 |-> rd_valid); // R7

  AST_UND_INVALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b110 |-> !rd_valid); // R8

  AST_UND_PULSE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 3'b110 |=> (rd_status == 3'b000 && !rd_valid)); // R8

endmodule

bind skp_elastic_buf eb_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_is_k(rd_is_k),
  .rd_status(rd_status), .wr_occ(wr_occ)
);

// File: tb/sim_skp_elastic_buf.sv
`timescale 1ns/1ps
module sim_skp_elastic_buf;

  localparam logic [7:0] COM = 8'hBC;
  localparam logic [7:0] SKP = 8'h1C;

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_is_k = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_is_k;
  logic [7:0] rd_data;
  logic [2:0] rd_status;

  real rd_half = 5.0;
  int  total = 0, bad = 0;
  int  n_ins = 0, n_del = 0, n_ovf = 0, n_und = 0;
  bit  seen_valid = 0, mon_on = 0, done = 0;
  bit  in_set = 0, ins_f = 0, ins_u = 0, del_f = 0, del_u = 0;
  logic [7:0] dctr = 8'h01;
  logic [8:0] exp_q [$];

  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  skp_elastic_buf u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_is_k(wr_is_k),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_is_k(rd_is_k),
    .rd_status(rd_status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: every symbol handed to the block is queued as expected output.
  task automatic send(input logic [7:0] d, input logic k);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_is_k  = k;
    exp_q.push_back({k, d});
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) begin
      send(dctr, 1'b0);
      dctr = dctr + 8'd1;
    end
  endtask

  task automatic send_groups(input int n);
    for (int i = 0; i < n; i++) begin
      send_data(8);
      send(COM, 1'b1);
      for (int j = 0; j < 3; j++) send(SKP, 1'b1);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge wr_clk) wr_valid = 1'b0;
  endtask

  task automatic handle_out();
    logic [8:0] o;
    bit o_skp, o_com;
    int drops;
    o     = {rd_is_k, rd_data};
    o_skp = (o == {1'b1, SKP});
    o_com = (o == {1'b1, COM});
    drops = 0;
    if (rd_status == 3'b101) begin
      n_ovf++;
      while (exp_q.size() > 0 && exp_q[0] != o) begin
        void'(exp_q.pop_front());
        drops++;
      end
      chk(drops > 0 && exp_q.size() > 0, "R7 drop before marked byte", drops, 1);
    end
    if (o_skp && in_set) begin
      chk(rd_status == 3'b000, "R9 status on SKP", int'(rd_status), 0);
      if (exp_q.size() > 0 && exp_q[0] == {1'b1, SKP}) begin
        void'(exp_q.pop_front());
      end else begin
        chk(ins_f && !ins_u, "R5 unflagged extra SKP", int'(o), exp_q.size() > 0 ? int'(exp_q[0]) : 0);
        ins_u = 1'b1;
      end
    end else begin
      if (in_set) begin
        if (exp_q.size() > 0 && exp_q[0] == {1'b1, SKP} && del_f && !del_u) begin
          void'(exp_q.pop_front());
          del_u = 1'b1;
        end
        chk(del_f == del_u, "R3 removal matches flag", int'(del_u), int'(del_f));
        chk(ins_f == ins_u, "R5 insertion matches flag", int'(ins_u), int'(ins_f));
      end
      in_set = 1'b0;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected output", int'(o), 0);
      end else begin
        chk(exp_q[0] == o, "R2 order", int'(o), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      if (o_com) begin
        in_set = 1'b1;
        ins_f  = (rd_status == 3'b001);
        del_f  = (rd_status == 3'b010);
        ins_u  = 1'b0;
        del_u  = 1'b0;
        if (ins_f) n_ins++;
        if (del_f) n_del++;
      end else begin
        chk(rd_status == 3'b000 || rd_status == 3'b101, "R9 status on data", int'(rd_status), 0);
      end
    end
  endtask

  // Monitor: compares each delivered symbol against the queue head.
  always @(negedge rd_clk) begin
    if (mon_on) begin
      if (rd_valid) seen_valid = 1'b1;
      if (rd_status == 3'b110) begin
        n_und++;
        chk(!rd_valid, "R8 invalid on underflow", int'(rd_valid), 0);
      end else if (!rd_valid) begin
        if (rd_status != 3'b000) chk(1'b0, "R9 idle status", int'(rd_status), 0);
      end else begin
        handle_out();
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      chk(1'b0, "R2 watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b_ins, b_del, b_ovf, b_und;
    #23;
    chk(rd_valid == 1'b0, "R1 reset valid", int'(rd_valid), 0);
    chk(rd_status == 3'b000, "R1 reset status", int'(rd_status), 0);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge rd_clk) rd_rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: fewer than START_LVL entries never start the reader.
    send_data(5);
    idle(20);
    chk(!seen_valid, "R1 no output before priming", int'(seen_valid), 0);

    // R6: equal rates keep the fill inside the band.
    b_ins = n_ins; b_del = n_del;
    send_groups(18);
    chk(n_ins == b_ins, "R6 no insertion at equal rate", n_ins - b_ins, 0);
    chk(n_del == b_del, "R6 no removal at equal rate", n_del - b_del, 0);

    // R3/R4: slower reader fills the buffer, removals must appear.
    rd_half = 5.25;
    b_del = n_del;
    send_groups(30);
    chk(n_del > b_del, "R3 removal under slow read", n_del - b_del, 1);
    chk(n_del > b_del, "R4 removal code seen", n_del - b_del, 1);

    // R5: faster reader drains the buffer, insertions must appear.
    rd_half = 4.75;
    b_ins = n_ins;
    send_groups(40);
    chk(n_ins > b_ins, "R5 insertion under fast read", n_ins - b_ins, 1);

    // R7: much slower reader with no SKP sets forces overflow drops.
    rd_half = 7.0;
    b_ovf = n_ovf;
    send_data(150);
    rd_half = 5.0;
    idle(80);
    chk(n_ovf > b_ovf, "R7 overflow code seen", n_ovf - b_ovf, 1);

    // R8: a starved reader reports underflow and resumes after refill.
    b_und = n_und;
    chk(n_und > 0, "R8 underflow code seen", n_und, 1);
    send_data(40);
    idle(80);
    chk(n_und > b_und, "R8 underflow after resumed stream", n_und - b_und, 1);
    chk(exp_q.size() == 1, "R2 all stored bytes delivered", exp_q.size(), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule